// File: doc/BRIEF.md
# Emulated Network Link Element

This block models one direction of one link inside a hardware model of a network, used to search for paths. A search word enters on a valid/word input and leaves on a valid/word output after a number of clock cycles equal to the link's cost. The lower part of the word is a bitmap with one bit per link, and the upper part holds a bandwidth value. As the word passes, the link sets its own bit in the bitmap. If the word's bandwidth value is larger than the link's remaining capacity, the link lowers it to that capacity. The first word to reach a destination therefore carries the cheapest route and the narrowest capacity along it.

A word that has already crossed this link is discarded, which keeps loops out of the search. Every accepted word counts towards a congestion threshold. Once the threshold is reached, the link's cost rises by a fixed step, so later words take longer and routes through a busy link become less attractive. In an initialisation mode, flooding words carry a traffic demand in their bandwidth field. The link subtracts each demand from its remaining capacity and does not forward the flooding word.

Top module: `emu_link`

## Requirements
- R1: A forwarded word leaves with bitmap bit LINK_IDX-1 set and every other bitmap bit unchanged. The bitmap is word bits [MAP_W-1:0]. For example, link 2 turns a zero bitmap into 24'h000002.
- R2: In normal mode, a word that arrives with bit LINK_IDX-1 already set produces no output and does not advance the congestion count.
- R3: A word accepted at clock edge t gives a one-cycle out_vld pulse after edge t+D, where D is the link delay in force at edge t. Several words can be in flight at once and they leave in arrival order.
- R4: Each accepted word advances the congestion count. The word that brings the count to THRESH still uses the old delay, and every later word uses BASE_DELAY+DELAY_INC. With the defaults, the delay goes from 8 to 10 after two words.
- R5: The output bandwidth field (bits [MAP_W+BW_W-1:MAP_W]) is the smaller of the input field and the link's remaining capacity.
- R6: With init_mode high, an input word is a flooding word whose demand sits in the bandwidth field. It lowers the remaining capacity by that demand, counts towards the threshold and is not forwarded. For example, 160 less 80 less 30 leaves 50.
- R7: Remaining capacity stops at zero instead of wrapping when a demand exceeds it.
- R8: A one-cycle clr restores the congestion count, the delay and the remaining capacity to their parameter values.
- R9: While rst_n is low, and right after it is released, out_vld and out_word are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Restores count, delay and capacity |
| init_mode | input | 1 | High: input words are flooding demand words |
| in_vld | input | 1 | Input word valid |
| in_word | input | MAP_W+BW_W | {bandwidth, link bitmap} |
| out_vld | output | 1 | Output word valid, one cycle |
| out_word | output | MAP_W+BW_W | Stamped, bandwidth-limited word |

## Verification
The assertions assume at most one input word per cycle and a delay that never shrinks except through clr or reset. Under those conditions the departure times stay strictly increasing, and the in-flight store, which is sized to the largest delay, cannot overflow. The stimulus drives only on falling edges and never presents more than one word per cycle. It issues clr before each table entry so that every entry sees the base delay and the full capacity. The back-to-back and congestion cases are left to directed tests, which follow the count from a known clear.

// File: rtl/emu_link.sv
module emu_link #(
  parameter int LINK_IDX   = 2,
  parameter int MAP_W      = 24,
  parameter int BW_W       = 8,
  parameter int BASE_DELAY = 8,
  parameter int THRESH     = 2,
  parameter int DELAY_INC  = 2,
  parameter int INIT_BW    = 160
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    init_mode,
  input  logic                    in_vld,
  input  logic [MAP_W+BW_W-1:0]   in_word,
  output logic                    out_vld,
  output logic [MAP_W+BW_W-1:0]   out_word
);
  localparam int WORD_W  = MAP_W + BW_W;
  localparam int MAX_DLY = BASE_DELAY + DELAY_INC;
  localparam int DEPTH   = (MAX_DLY < 2) ? 2 : MAX_DLY;
  localparam int PW      = $clog2(DEPTH);
  localparam int DW      = $clog2(MAX_DLY + 1);
  localparam int TS_W    = $clog2(MAX_DLY + 1) + 1;
  localparam int CNT_W   = $clog2(THRESH + 1);

  logic [WORD_W-1:0] word_q [DEPTH];
  logic [TS_W-1:0]   dep_q  [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [PW:0]       fill;
  logic [TS_W-1:0]   now;
  logic [DW-1:0]     cur_dly;
  logic [CNT_W-1:0]  cnt;
  logic [BW_W-1:0]   rem_bw;

  wire              own    = in_word[LINK_IDX-1];
  wire              acc    = in_vld && (init_mode || !own);
  wire              fwd    = in_vld && !init_mode && !own;
  wire [BW_W-1:0]   in_bw  = in_word[WORD_W-1:MAP_W];
  wire [BW_W-1:0]   lo_bw  = (in_bw > rem_bw) ? rem_bw : in_bw;
  wire [MAP_W-1:0]  mask   = MAP_W'(1) << (LINK_IDX - 1);
  wire [WORD_W-1:0] stamped = {lo_bw, in_word[MAP_W-1:0] | mask};
  wire              due    = (fill != '0) && (dep_q[rd_ptr] == now);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (fwd) begin
      word_q[wr_ptr] <= stamped;
      dep_q[wr_ptr]  <= now + TS_W'(cur_dly);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now      <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      out_vld  <= 1'b0;
      out_word <= '0;
    end else begin
      now     <= now + 1'b1;
      out_vld <= due;
      if (due) out_word <= word_q[rd_ptr];
      if (fwd) wr_ptr <= step(wr_ptr);
      if (due) rd_ptr <= step(rd_ptr);
      case ({fwd, due})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt     <= '0;
      cur_dly <= DW'(BASE_DELAY);
      rem_bw  <= BW_W'(INIT_BW);
    end else begin
      if (acc && cnt < CNT_W'(THRESH)) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(THRESH - 1)) cur_dly <= cur_dly + DW'(DELAY_INC);
      end
      if (in_vld && init_mode)
        rem_bw <= (in_bw >= rem_bw) ? '0 : rem_bw - in_bw;
    end
  end
endmodule

// File: rtl/emu_link_chk.sv
module emu_link_chk #(
  parameter int LINK_IDX   = 2,
  parameter int MAP_W      = 24,
  parameter int BW_W       = 8,
  parameter int BASE_DELAY = 8,
  parameter int DELAY_INC  = 2,
  parameter int INIT_BW    = 160,
  parameter int DW         = 4,
  parameter int PW         = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr,
  input logic                  fwd,
  input logic [PW:0]           fill,
  input logic [DW-1:0]         cur_dly,
  input logic [BW_W-1:0]       rem_bw,
  input logic                  out_vld,
  input logic [MAP_W+BW_W-1:0] out_word
);
  localparam int DEPTH = ((BASE_DELAY + DELAY_INC) < 2) ? 2 : BASE_DELAY + DELAY_INC;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> fill < (PW+1)'(DEPTH)); // R3
  AST_STAMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_word[LINK_IDX-1]); // R1
  AST_BW_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_word[MAP_W+BW_W-1:MAP_W] <= BW_W'(INIT_BW)); // R5
  AST_DELAY_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && $past(rst_n)) |-> cur_dly >= $past(cur_dly)); // R4
  AST_BW_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr) && $past(rst_n)) |-> rem_bw <= $past(rem_bw)); // R7
endmodule

bind emu_link emu_link_chk #(
  .LINK_IDX(LINK_IDX), .MAP_W(MAP_W), .BW_W(BW_W), .BASE_DELAY(BASE_DELAY),
  .DELAY_INC(DELAY_INC), .INIT_BW(INIT_BW), .DW(DW), .PW(PW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .fwd(fwd), .fill(fill),
  .cur_dly(cur_dly), .rem_bw(rem_bw), .out_vld(out_vld), .out_word(out_word)
);

// File: tb/emu_link_tb.sv
module emu_link_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam logic [31:0] VIN [NV] = '{{8'd255, 24'h0}, {8'd80, 24'h1},
                                       {8'd160, 24'h100}, {8'd0, 24'h4}};
  localparam logic [31:0] VEXP[NV] = '{{8'd160, 24'h2}, {8'd80, 24'h3},
                                       {8'd160, 24'h102}, {8'd0, 24'h6}};

  logic clk = 0, rst_n = 0, clr = 0, init_mode = 0, in_vld = 0;
  logic [31:0] in_word = '0;
  logic out_vld;
  logic [31:0] out_word;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  emu_link dut_i (.clk(clk), .rst_n(rst_n), .clr(clr), .init_mode(init_mode),
    .in_vld(in_vld), .in_word(in_word), .out_vld(out_vld), .out_word(out_word));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_clr();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic send(input logic [31:0] w, input logic m);
    init_mode = m; in_word = w; in_vld = 1;
    @(negedge clk);
    in_vld = 0; init_mode = 0;
  endtask

  task automatic wait_out(output int lat, output logic [31:0] w);
    lat = 0; w = '0;
    while (lat < 20) begin
      @(negedge clk); lat++;
      if (out_vld) begin w = out_word; break; end
    end
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (out_vld) seen++; end
    chk(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    chk(out_vld == 0 && out_word == 0, "R9 reset", {31'd0, out_vld}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_vld == 0 && out_word == 0, "R9 after reset", out_word, 0);

    for (int i = 0; i < NV; i++) begin
      do_clr();
      send(VIN[i], 0);
      wait_out(lat, w);
      chk(lat == 8, "R3 table latency", lat, 8);
      chk(w == VEXP[i], "R1 R5 table word", w, VEXP[i]);
    end

    // R2: own bit set is dropped and not counted
    do_clr();
    send({8'd255, 24'h2}, 0);
    quiet(14, "R2 loop drop");
    send({8'd255, 24'h0}, 0); wait_out(lat, w);
    chk(lat == 8, "R2 count untouched", lat, 8);
    send({8'd255, 24'h0}, 0); wait_out(lat, w);
    chk(lat == 8, "R4 threshold word old delay", lat, 8);
    send({8'd255, 24'h0}, 0); wait_out(lat, w);
    chk(lat == 10, "R4 delay raised", lat, 10);

    // R6: flooding demand
    do_clr();
    send({8'd80, 24'h0}, 1);
    send({8'd30, 24'h0}, 1);
    quiet(12, "R6 flood not forwarded");
    send({8'd255, 24'h0}, 0); wait_out(lat, w);
    chk(w == {8'd50, 24'h2}, "R6 remaining capacity", w, {8'd50, 24'h2});
    chk(lat == 10, "R6 flood counted", lat, 10);

    // R7: saturation
    send({8'd200, 24'h0}, 1);
    send({8'd255, 24'h0}, 0); wait_out(lat, w);
    chk(w == {8'd0, 24'h2}, "R7 saturate", w, {8'd0, 24'h2});

    // R8: clear
    do_clr();
    send({8'd255, 24'h0}, 0); wait_out(lat, w);
    chk(lat == 8, "R8 delay restored", lat, 8);
    chk(w == {8'd160, 24'h2}, "R8 capacity restored", w, {8'd160, 24'h2});

    // R3: back-to-back, in order, third uses raised delay
    begin
      int at [3];
      logic [31:0] got [3];
      int k = 0;
      do_clr();
      in_vld = 1; in_word = {8'd10, 24'h10}; @(negedge clk);
      in_word = {8'd20, 24'h20}; @(negedge clk);
      in_word = {8'd30, 24'h40}; @(negedge clk);
      in_vld = 0;
      for (int j = 3; j <= 20; j++) begin
        @(negedge clk);
        if (out_vld && k < 3) begin at[k] = j; got[k] = out_word; k++; end
      end
      chk(k == 3, "R3 count", k, 3);
      chk(at[0] == 8 && at[1] == 9, "R3 spacing", at[1], 9);
      chk(at[2] == 12, "R4 third late", at[2], 12);
      chk(got[0] == {8'd10, 24'h12} && got[1] == {8'd20, 24'h22} && got[2] == {8'd30, 24'h42},
          "R3 order", got[2], {8'd30, 24'h42});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule